// File: doc/BRIEF.md
# Hysteresis Threshold Programming Unit

This block keeps a falling and a rising voltage threshold, in whole volts, for each of several sensing modes (two by default). A caller presents one update request at a time, naming the mode, the edge (rising or falling) and the new value. The block checks the value against a fixed legal window and against the opposite threshold of the same mode. It accepts or rejects the request, and on a real change it writes back both thresholds of that mode as a single 16-bit configuration word.

Hysteresis must never be odd. When an accepted update would leave an odd gap, the block moves the opposite threshold of that mode by one volt toward the new value before it encodes the word. The word carries the gap between the thresholds in its upper byte and their sum in its lower byte. A separate combinational path turns any such word read back from the detector into falling and rising volts.

Top module: `thr_prog_unit`

## Requirements
- R1: A falling request (req_rising_i=0) is accepted only when its value lies in 2..21 and the value plus 2 does not exceed the stored rising threshold of the same mode. Any other falling request is rejected.
- R2: A rising request (req_rising_i=1) is accepted only when its value lies in 3..22 and is at least the stored falling threshold of the same mode plus 2. Any other rising request is rejected.
- R3: An accepted request whose value equals the threshold already stored for that mode and edge raises ack_o with wr_o low and changes nothing.
- R4: After an accepted falling change, if rising minus falling is odd, the rising threshold drops by 1. After an accepted rising change with an odd difference, the falling threshold rises by 1.
- R5: An accepted change raises ack_o and wr_o in the cycle after the request. wr_mode_o carries the request's mode. wr_word_o[15:8] carries rising minus falling and wr_word_o[7:0] carries rising plus falling, both taken after adjustment.
- R6: The decode path gives rd_fall_o = floor((rd_word_i[7:0] - rd_word_i[15:8]) / 2) and rd_rise_o = floor((rd_word_i[7:0] + rd_word_i[15:8]) / 2) in the same cycle.
- R7: After reset every mode holds falling = 2 and rising = 4, and ack_o, err_o and wr_o are low.
- R8: A rejected request raises err_o for one cycle, with ack_o and wr_o low, and leaves both thresholds of every mode unchanged.
- R9: An update to one mode never changes the thresholds of any other mode.
- R10: Each request yields exactly one of ack_o or err_o in the following cycle. Neither is raised in a cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Update request present this cycle |
| req_mode_i | input | 1 | Sensing mode addressed by the request |
| req_rising_i | input | 1 | 1: rising threshold, 0: falling threshold |
| req_value_i | input | 8 | Requested threshold in volts |
| ack_o | output | 1 | Request accepted (one-cycle pulse) |
| err_o | output | 1 | Request rejected (one-cycle pulse) |
| wr_o | output | 1 | Write strobe for the configuration word |
| wr_mode_o | output | 1 | Mode that the written word belongs to |
| wr_word_o | output | 16 | Encoded word: {difference, sum} |
| rd_word_i | input | 16 | Configuration word read back from the detector |
| rd_fall_o | output | 8 | Falling threshold decoded from rd_word_i |
| rd_rise_o | output | 8 | Rising threshold decoded from rd_word_i |

## Verification
The parity correction is the hardest case to reach from the ports. It only fires when the requested value lands an odd distance from the opposite threshold, and that threshold is itself the product of earlier accepted updates. A directed run walks one mode to a wide even gap and then steps a single edge by one volt, so each kind of correction fires at least once. Several hundred random requests over both modes, both edges and values slightly outside the legal window then mix corrections, rejections and no-change requests. A bench model of the stored pairs predicts every result.

// File: rtl/thr_prog_pkg.sv
package thr_prog_pkg;
  localparam int unsigned VAL_W  = 8;
  localparam int unsigned WORD_W = 2 * VAL_W;

  typedef logic [VAL_W-1:0]  volt_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    volt_t rise;
    volt_t fall;
  } thr_pair_t;
endpackage

// File: rtl/thr_req_check.sv
module thr_req_check
  import thr_prog_pkg::*;
#(
  parameter int unsigned FALL_MIN = 2,
  parameter int unsigned FALL_MAX = 21,
  parameter int unsigned RISE_MIN = 3,
  parameter int unsigned RISE_MAX = 22,
  parameter int unsigned MIN_HYST = 2
) (
  input  logic      rising_i,
  input  volt_t     value_i,
  input  thr_pair_t cur_i,
  output logic      ok_o,
  output logic      same_o
);
  localparam int unsigned EXT_W = VAL_W + 1;

  logic [EXT_W-1:0] val_ext;
  logic [EXT_W-1:0] val_plus_hyst;
  logic [EXT_W-1:0] fall_plus_hyst;
  logic             fall_ok;
  logic             rise_ok;

  assign val_ext        = {1'b0, value_i};
  assign val_plus_hyst  = val_ext + EXT_W'(MIN_HYST);
  assign fall_plus_hyst = {1'b0, cur_i.fall} + EXT_W'(MIN_HYST);

  always_comb begin
    fall_ok = (val_ext >= EXT_W'(FALL_MIN)) && (val_ext <= EXT_W'(FALL_MAX)) &&
              (val_plus_hyst <= {1'b0, cur_i.rise});
    rise_ok = (val_ext >= EXT_W'(RISE_MIN)) && (val_ext <= EXT_W'(RISE_MAX)) &&
              (val_ext >= fall_plus_hyst);
    ok_o    = rising_i ? rise_ok : fall_ok;
    same_o  = rising_i ? (value_i == cur_i.rise) : (value_i == cur_i.fall);
  end
endmodule

// File: rtl/thr_even_adjust.sv
module thr_even_adjust
  import thr_prog_pkg::*;
(
  input  logic      rising_i,
  input  volt_t     value_i,
  input  thr_pair_t cur_i,
  output thr_pair_t nxt_o
);
  volt_t gap;

  always_comb begin
    nxt_o = cur_i;
    if (rising_i) begin
      gap        = value_i - cur_i.fall;
      nxt_o.rise = value_i;
      // odd gap: pull falling edge up
      if (gap[0]) nxt_o.fall = cur_i.fall + volt_t'(1);
    end else begin
      gap        = cur_i.rise - value_i;
      nxt_o.fall = value_i;
      // odd gap: pull rising edge down
      if (gap[0]) nxt_o.rise = cur_i.rise - volt_t'(1);
    end
  end
endmodule

// File: rtl/thr_word_enc.sv
module thr_word_enc
  import thr_prog_pkg::*;
(
  input  thr_pair_t pair_i,
  output word_t     word_o
);
  volt_t diff;
  volt_t sum;

  assign diff   = pair_i.rise - pair_i.fall;
  assign sum    = pair_i.rise + pair_i.fall;
  assign word_o = {diff, sum};
endmodule

// File: rtl/thr_word_dec.sv
module thr_word_dec
  import thr_prog_pkg::*;
(
  input  word_t     word_i,
  output thr_pair_t pair_o
);
  volt_t        hi_b;
  volt_t        lo_b;
  volt_t        dif;
  logic [VAL_W:0] sum;

  assign hi_b = word_i[WORD_W-1:VAL_W];
  assign lo_b = word_i[VAL_W-1:0];
  assign dif  = lo_b - hi_b;
  assign sum  = {1'b0, lo_b} + {1'b0, hi_b};

  assign pair_o.fall = dif >> 1;
  assign pair_o.rise = sum[VAL_W:1];
endmodule

// File: rtl/thr_prog_unit.sv
module thr_prog_unit
  import thr_prog_pkg::*;
#(
  parameter int unsigned NUM_MODES  = 2,
  parameter int unsigned FALL_MIN   = 2,
  parameter int unsigned FALL_MAX   = 21,
  parameter int unsigned RISE_MIN   = 3,
  parameter int unsigned RISE_MAX   = 22,
  parameter int unsigned MIN_HYST   = 2,
  parameter int unsigned RESET_FALL = 2,
  parameter int unsigned RESET_RISE = 4,
  localparam int unsigned MODE_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              req_rising_i,
  input  logic [VAL_W-1:0]  req_value_i,
  output logic              ack_o,
  output logic              err_o,
  output logic              wr_o,
  output logic [MODE_W-1:0] wr_mode_o,
  output logic [WORD_W-1:0] wr_word_o,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [VAL_W-1:0]  rd_fall_o,
  output logic [VAL_W-1:0]  rd_rise_o
);
  thr_pair_t thr_q [NUM_MODES];
  thr_pair_t cur_pair;
  thr_pair_t nxt_pair;
  thr_pair_t rd_pair;
  word_t     nxt_word;
  logic      req_ok;
  logic      req_same;
  logic      do_update;

  // select the addressed mode
  always_comb begin
    cur_pair = thr_q[0];
    for (int m = 1; m < NUM_MODES; m++) begin
      if (req_mode_i == MODE_W'(m)) cur_pair = thr_q[m];
    end
  end

  thr_req_check #(
    .FALL_MIN (FALL_MIN),
    .FALL_MAX (FALL_MAX),
    .RISE_MIN (RISE_MIN),
    .RISE_MAX (RISE_MAX),
    .MIN_HYST (MIN_HYST)
  ) u_check (
    .rising_i (req_rising_i),
    .value_i  (req_value_i),
    .cur_i    (cur_pair),
    .ok_o     (req_ok),
    .same_o   (req_same)
  );

  thr_even_adjust u_adjust (
    .rising_i (req_rising_i),
    .value_i  (req_value_i),
    .cur_i    (cur_pair),
    .nxt_o    (nxt_pair)
  );

  thr_word_enc u_enc (
    .pair_i (nxt_pair),
    .word_o (nxt_word)
  );

  thr_word_dec u_dec (
    .word_i (rd_word_i),
    .pair_o (rd_pair)
  );

  assign rd_fall_o = rd_pair.fall;
  assign rd_rise_o = rd_pair.rise;
  assign do_update = req_valid_i && req_ok && !req_same;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        thr_q[g].fall <= volt_t'(RESET_FALL);
        thr_q[g].rise <= volt_t'(RESET_RISE);
      end else if (do_update && (req_mode_i == MODE_W'(g))) begin
        thr_q[g] <= nxt_pair;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o     <= 1'b0;
      err_o     <= 1'b0;
      wr_o      <= 1'b0;
      wr_mode_o <= '0;
      wr_word_o <= '0;
    end else begin
      ack_o <= req_valid_i && req_ok;
      err_o <= req_valid_i && !req_ok;
      wr_o  <= do_update;
      if (do_update) begin
        wr_mode_o <= req_mode_i;
        wr_word_o <= nxt_word;
      end
    end
  end
endmodule

// File: rtl/thr_prog_unit_chk.sv
module thr_prog_unit_chk
  import thr_prog_pkg::*;
#(
  parameter int unsigned MODE_W   = 1,
  parameter int unsigned FALL_MIN = 2,
  parameter int unsigned FALL_MAX = 21,
  parameter int unsigned RISE_MIN = 3,
  parameter int unsigned RISE_MAX = 22,
  parameter int unsigned MIN_HYST = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [MODE_W-1:0] req_mode_i,
  input logic              ack_o,
  input logic              err_o,
  input logic              wr_o,
  input logic [MODE_W-1:0] wr_mode_o,
  input logic [WORD_W-1:0] wr_word_o
);
  volt_t w_hi;
  volt_t w_lo;
  volt_t w_fall;
  volt_t w_rise;

  assign w_hi   = wr_word_o[WORD_W-1:VAL_W];
  assign w_lo   = wr_word_o[VAL_W-1:0];
  assign w_fall = volt_t'((w_lo - w_hi) >> 1);
  assign w_rise = volt_t'(({1'b0, w_lo} + {1'b0, w_hi}) >> 1);

  assert_resp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || err_o) |-> $past(req_valid_i));
  assert_req_gets_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i) |-> (ack_o != err_o));
  assert_write_needs_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ack_o);
  assert_reject_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_o);
  assert_even_hyst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (!w_hi[0] && (w_hi >= volt_t'(MIN_HYST))));
  assert_fall_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ((w_fall >= volt_t'(FALL_MIN)) && (w_fall <= volt_t'(FALL_MAX))));
  assert_rise_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ((w_rise >= volt_t'(RISE_MIN)) && (w_rise <= volt_t'(RISE_MAX))));
  assert_write_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (wr_mode_o == $past(req_mode_i)));
endmodule

bind thr_prog_unit thr_prog_unit_chk #(
  .MODE_W   (MODE_W),
  .FALL_MIN (FALL_MIN),
  .FALL_MAX (FALL_MAX),
  .RISE_MIN (RISE_MIN),
  .RISE_MAX (RISE_MAX),
  .MIN_HYST (MIN_HYST)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_mode_i  (req_mode_i),
  .ack_o       (ack_o),
  .err_o       (err_o),
  .wr_o        (wr_o),
  .wr_mode_o   (wr_mode_o),
  .wr_word_o   (wr_word_o)
);

// File: tb/thr_prog_unit_test.sv
module thr_prog_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [0:0]  req_mode = '0;
  logic        req_rising = 1'b0;
  logic [7:0]  req_value = '0;
  logic        ack, err, wr;
  logic [0:0]  wr_mode;
  logic [15:0] wr_word;
  logic [15:0] rd_word = '0;
  logic [7:0]  rd_fall, rd_rise;

  int checks = 0;
  int errors = 0;
  int mf [2];
  int mr [2];

  always #10 clk = ~clk;

  thr_prog_unit uut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_mode_i (req_mode),
    .req_rising_i (req_rising), .req_value_i (req_value),
    .ack_o (ack), .err_o (err), .wr_o (wr),
    .wr_mode_o (wr_mode), .wr_word_o (wr_word),
    .rd_word_i (rd_word), .rd_fall_o (rd_fall), .rd_rise_o (rd_rise)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drives at a falling edge, checks at the next falling edge
  task automatic send(input int m, input bit rising, input int v, input string tag);
    bit ok, same;
    int nf, nr;
    logic [15:0] ew;
    nf = mf[m]; nr = mr[m];
    if (rising) begin
      ok = (v >= 3) && (v <= 22) && (v >= mf[m] + 2);
      same = (v == mr[m]);
      nr = v;
      if (((nr - nf) % 2) != 0) nf = nf + 1;
    end else begin
      ok = (v >= 2) && (v <= 21) && (v + 2 <= mr[m]);
      same = (v == mf[m]);
      nf = v;
      if (((nr - nf) % 2) != 0) nr = nr - 1;
    end
    ew = {8'(nr - nf), 8'(nr + nf)};
    req_valid = 1'b1; req_mode = 1'(m); req_rising = rising; req_value = 8'(v);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check({tag, " ack/err R10"}, {30'd0, ack, err}, {30'd0, ok, !ok});
    if (!ok) check({tag, " reject R8"}, {31'd0, wr}, 32'd0);
    else if (same) check({tag, " same R3"}, {31'd0, wr}, 32'd0);
    else begin
      check({tag, " write R5 R4"}, {15'd0, wr, wr_mode, wr_word},
            {15'd0, 1'b1, 1'(m), ew});
      mf[m] = nf; mr[m] = nr;
    end
  endtask

  task automatic decode(input logic [15:0] w);
    int lo, hi;
    lo = int'(w[7:0]); hi = int'(w[15:8]);
    rd_word = w;
    #1;
    check("decode R6", {16'd0, rd_fall, rd_rise},
          {16'd0, 8'(((lo - hi) & 255) >> 1), 8'((lo + hi) >> 1)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) begin mf[m] = 2; mr[m] = 4; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset outputs R7", {29'd0, ack, err, wr}, 32'd0);
    // reset values seen as no-change accepts
    send(0, 0, 2, "rst fall m0 R7");
    send(1, 1, 4, "rst rise m1 R7");
    send(0, 1, 3, "rise 3 too close R2");
    send(0, 0, 3, "fall 3 too close R1");
    // walk mode 0 to a wide even gap
    send(0, 1, 22, "rise max R2");
    send(0, 1, 23, "rise over R2");
    send(0, 0, 21, "fall no margin R1");
    send(0, 0, 1, "fall under R1");
    send(0, 0, 20, "fall 20 R1");
    send(0, 0, 19, "fall odd adjust R4");
    send(0, 1, 20, "rise below margin R2");
    send(0, 0, 2, "fall back R1");
    send(0, 1, 7, "rise odd adjust R4");
    // mode 1 untouched by mode 0 history
    send(1, 0, 2, "m1 isolation R9");
    send(1, 1, 5, "m1 rise odd R4 R9");
    send(0, 0, 3, "m0 same after m1 R9");
    for (int i = 0; i < 500; i++)
      send(int'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
           int'($urandom_range(25, 0)), "random R1 R2");
    decode(16'h0206);
    decode(16'h0207);
    decode({8'd20, 8'd24});
    for (int i = 0; i < 20; i++) begin
      int f, r;
      f = int'($urandom_range(21, 2));
      r = f + 2 * int'($urandom_range((22 - f) / 2, 1));
      decode({8'(r - f), 8'(r + f)});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule